// File: doc/BRIEF.md
# Dual-Compare Pulse Output Unit

This block drives one output pin from a free-running up-counter and two compare values. The counter advances once per clock while counting is enabled. When it reaches a programmable period value it returns to zero. One compare value sets the start of a pulse and the other sets its end. A one-cycle interrupt strobe marks the end of each pulse.

A mode input selects between two behaviours. In single-shot mode the unit emits one pulse and then stays quiet until software re-arms it. In repeating mode the same pulse appears in every timer period.

When the unit is disabled, the pin carries a general-purpose output value. When the unit is enabled, the compare logic owns the pin and the general-purpose value has no effect on it.

Top module: `dual_cmp_pulse`

## Requirements
- R1: While `tmr_en` is high, `timer_q` increments by one each clock. In a cycle where `timer_q` is greater than or equal to `period`, the next value is 0 instead.
- R2: While `tmr_en` is low, `timer_q` holds its value and neither compare value produces a match.
- R3: With `en` high, no pulse in progress and the unit armed, a cycle in which `timer_q` equals `cmp_lead` drives `pin_out` high from the next clock.
- R4: With a pulse in progress, a cycle in which `timer_q` equals `cmp_trail` drives `pin_out` low from the next clock. In that same next cycle `match_irq` is high for exactly one cycle.
- R5: With `continuous` low (single-shot), the end of a pulse disarms the unit, and no further lead match starts a pulse. Re-arming takes either an `arm` pulse or a low-then-high cycle of `en`. If `arm` is high in the cycle of the trailing match, the unit stays armed.
- R6: With `continuous` high (repeating), the unit is never disarmed, so the pulse repeats in every timer period.
- R7: A compare value greater than `period` never matches while `period` is unchanged, so that edge never occurs.
- R8: While `en` is low, `pin_out` equals `gp_out`, the pulse state and the armed state are cleared, and `match_irq` stays low. While `en` is high, `gp_out` has no effect on `pin_out`.
- R9: After reset, `timer_q` is 0, `match_irq` is 0 and the pulse state is low. With `en` and `gp_out` low, `pin_out` is low.
- R10: When `cmp_lead` equals `cmp_trail`, a match during a pulse ends it, and a match with no pulse in progress starts one (subject to R5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Gives the pin to the compare logic; low clears the unit |
| tmr_en | input | 1 | Timer count enable |
| continuous | input | 1 | 1 = repeating pulse train, 0 = single-shot |
| arm | input | 1 | Re-arm strobe for single-shot mode |
| gp_out | input | 1 | General-purpose pin value, used while `en` is low |
| period | input | W | Timer period (last count before returning to zero) |
| cmp_lead | input | W | Count value at which the pulse starts |
| cmp_trail | input | W | Count value at which the pulse ends |
| timer_q | output | W | Current timer count |
| pin_out | output | 1 | Output pin |
| match_irq | output | 1 | One-cycle strobe on each trailing-edge match |

## Verification
The lead and trail matches can fall in the same cycle, and so can the timer wrap. This happens whenever `cmp_lead` equals `cmp_trail`, or either equals `period`. The bench sweeps every pair of compare values, including equal pairs and values above the period, for several periods in both modes. It drops `tmr_en` at intervals and inserts a re-arm strobe partway through each single-shot run. An arithmetic model in the bench predicts the count, the pin level and the strobe every cycle. In coinciding cycles it judges that an active pulse ends and that an idle, armed unit starts one.

// File: rtl/dual_cmp_pulse.sv
module dual_cmp_pulse #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tmr_en,
  input  logic         continuous,
  input  logic         arm,
  input  logic         gp_out,
  input  logic [W-1:0] period,
  input  logic [W-1:0] cmp_lead,
  input  logic [W-1:0] cmp_trail,
  output logic [W-1:0] timer_q,
  output logic         pin_out,
  output logic         match_irq
);

  logic [W-1:0] tmr;
  logic oc_q, done_q, irq_q;

  wire wrap        = (tmr >= period);
  wire lead_hit    = tmr_en && (tmr == cmp_lead);
  wire trail_hit   = tmr_en && (tmr == cmp_trail);
  wire end_pulse   = en && oc_q && trail_hit;
  wire start_pulse = en && !oc_q && !done_q && lead_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)      tmr <= '0;
    else if (tmr_en) tmr <= wrap ? '0 : tmr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      oc_q   <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= end_pulse;
      if (end_pulse)        oc_q <= 1'b0;
      else if (start_pulse) oc_q <= 1'b1;
      if (arm)                              done_q <= 1'b0;
      else if (end_pulse && !continuous)    done_q <= 1'b1;
    end
  end

  assign timer_q   = tmr;
  assign match_irq = irq_q;
  assign pin_out   = en ? oc_q : gp_out;

  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_en && timer_q >= period) |=> (timer_q == '0));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |=> $stable(timer_q));

  assert_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> oc_q);

  assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq |=> !match_irq);

  assert_irq_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq |-> !oc_q);

  assert_disarmed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && done_q && !arm) |=> !oc_q);

  assert_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!oc_q && !match_irq));

endmodule

// File: tb/dual_cmp_pulse_tb_top.sv
module dual_cmp_pulse_tb_top;
  localparam int CLK_NS = 10;
  localparam int W = 4;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0, en = 1'b0, tmr_en = 1'b0, continuous = 1'b0, arm = 1'b0, gp_out = 1'b0;
  logic [W-1:0] period = '0, cmp_lead = '0, cmp_trail = '0;
  logic [W-1:0] timer_q;
  logic pin_out, match_irq;

  int vectors = 0;
  int errors  = 0;

  always #(CLK_NS/2) clk = ~clk;

  dual_cmp_pulse #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .tmr_en(tmr_en), .continuous(continuous),
    .arm(arm), .gp_out(gp_out), .period(period), .cmp_lead(cmp_lead),
    .cmp_trail(cmp_trail), .timer_q(timer_q), .pin_out(pin_out), .match_irq(match_irq)
  );

  // Reference model built from the requirements
  logic [W-1:0] m_tmr = '0;
  logic m_oc = 1'b0, m_done = 1'b0, m_irq = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tmr <= '0; m_oc <= 1'b0; m_done <= 1'b0; m_irq <= 1'b0;
    end else begin
      if (tmr_en) m_tmr <= (m_tmr >= period) ? '0 : W'(m_tmr + 1);
      if (!en) begin
        m_oc <= 1'b0; m_done <= 1'b0; m_irq <= 1'b0;
      end else begin
        m_irq <= 1'b0;
        if (m_oc && tmr_en && m_tmr == cmp_trail) begin
          m_oc <= 1'b0; m_irq <= 1'b1;
          if (!continuous) m_done <= 1'b1;
        end else if (!m_oc && !m_done && tmr_en && m_tmr == cmp_lead) begin
          m_oc <= 1'b1;
        end
        if (arm) m_done <= 1'b0;
      end
    end
  end

  task automatic check(input string tag);
    logic exp_pin;
    exp_pin = en ? m_oc : gp_out;
    vectors++;
    if (timer_q !== m_tmr) begin
      errors++;
      $display("FAIL R1 [%s] timer actual=%0d expected=%0d", tag, timer_q, m_tmr);
    end
    if (pin_out !== exp_pin) begin
      errors++;
      $display("FAIL R3 [%s] pin actual=%b expected=%b p=%0d l=%0d t=%0d", tag, pin_out, exp_pin,
               period, cmp_lead, cmp_trail);
    end
    if (match_irq !== m_irq) begin
      errors++;
      $display("FAIL R4 [%s] irq actual=%b expected=%b", tag, match_irq, m_irq);
    end
  endtask

  task automatic step(input string tag);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(CLK_NS * LIMIT);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int pvals[4];
    int pulses;
    pvals[0] = 2; pvals[1] = 5; pvals[2] = 9; pvals[3] = 15;
    // R9 reset state
    repeat (3) step("R9");
    rst_n = 1'b1;
    step("R9");
    // R8 general-purpose pass-through while disabled
    tmr_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      gp_out = i[0];
      step("R8");
    end
    // R8 gp has no effect while enabled
    period = 4'd7; cmp_lead = 4'd2; cmp_trail = 4'd5; continuous = 1'b1; en = 1'b1;
    for (int i = 0; i < 20; i++) begin
      gp_out = ~gp_out;
      step("R8");
    end
    // R6 count pulses in repeating mode
    pulses = 0;
    for (int i = 0; i < 32; i++) begin
      step("R6");
      if (match_irq) pulses++;
    end
    vectors++;
    if (pulses != 4) begin
      errors++;
      $display("FAIL R6 pulse count actual=%0d expected=4", pulses);
    end
    // R2 timer frozen
    tmr_en = 1'b0;
    repeat (5) step("R2");
    tmr_en = 1'b1;
    // Sweep: periods, all compare pairs, both modes
    foreach (pvals[pi]) begin
      for (int l = 0; l < 12; l++) begin
        for (int t = 0; t < 12; t++) begin
          for (int c = 0; c < 2; c++) begin
            string tag;
            int run;
            if (l > pvals[pi] || t > pvals[pi]) tag = "R7";
            else if (l == t)                    tag = "R10";
            else if (c == 1)                    tag = "R6";
            else                                tag = "R5";
            en = 1'b0;
            gp_out = l[0] ^ t[0];
            step(tag);
            period = W'(pvals[pi]); cmp_lead = W'(l); cmp_trail = W'(t);
            continuous = c[0]; en = 1'b1;
            run = 3 * (pvals[pi] + 1) + 2;
            for (int k = 0; k < run; k++) begin
              tmr_en = (k % 7) != 6;
              arm = (c == 0) && (k == 2 * (pvals[pi] + 1) - 1);
              gp_out = k[1];
              step(tag);
            end
            arm = 1'b0; tmr_en = 1'b1;
          end
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule